// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Signed Overflow Flag

This block is the integer execution unit of a small load/store processor. Each cycle it accepts two 32-bit operands, a 5-bit constant shift distance and a 5-bit operation code. It computes one of nineteen operations: add and subtract (each in a flagging and a silent form), four bitwise logic functions, signed and unsigned less-than tests, six shifts, two rotates and an upper-half load. The result word and an overflow flag are registered at the next rising clock edge.

Immediate extension, register-file access, decode and exception handling are done elsewhere. The pipeline uses the overflow flag to decide whether a trap is taken. The shift forms that read their distance from the constant field use `shamt_i`. The register-distance forms and both rotates use the low five bits of `b_i`.

Top module: `int_alu_core`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o` becomes 0 and `ovf_o` becomes 0 after that edge.
- R2: Outputs are registered. A change on the inputs appears on `result_o`/`ovf_o` only after the next rising edge, and never before it.
- R3: Opcode 0 (ADD) gives a+b modulo 2^32. It sets `ovf_o` when a and b have the same sign bit and the sum's sign bit differs from it.
- R4: Opcode 2 (SUB) gives a-b modulo 2^32. It sets `ovf_o` when the sign bits of a and b differ and the difference's sign bit differs from a's.
- R5: Opcodes 1 (ADDU) and 3 (SUBU) give the same wrapped sum or difference as ADD and SUB, with `ovf_o` always 0.
- R6: Opcodes 4 AND, 5 OR, 6 XOR and 7 NOR apply the named function bitwise to a and b.
- R7: Opcodes 8 (SLT, signed) and 9 (SLTU, unsigned) return 1 in bit 0 when a<b and 0 otherwise. Bits 31:1 are always 0.
- R8: Opcodes 10 SLL, 11 SRL and 12 SRA shift a by `shamt_i`. SRL fills with zeros and SRA fills with a's bit 31. A distance of 0 returns a unchanged.
- R9: Opcodes 13 SLLV, 14 SRLV and 15 SRAV behave like 10 to 12 but take the distance from b[4:0]. Bits 31:5 of b and `shamt_i` have no effect.
- R10: Opcodes 16 (ROL) and 17 (ROR) rotate a left or right by b[4:0]. Bits leaving one end re-enter at the other end, and a distance of 0 returns a.
- R11: Opcode 18 (LUI) puts b[15:0] in result bits 31:16 and zeros in bits 15:0. Operand a has no effect.
- R12: `ovf_o` is 0 for every opcode other than 0 and 2. Opcodes 19 to 31 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 5 | Operation code (see requirements) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; supplies register shift/rotate distance and upper-load value |
| shamt_i | input | 5 | Constant shift distance |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
Every result and overflow flag is due exactly one rising edge after the operands and opcode are presented, for every opcode alike. The bench drives inputs on a falling edge and reads the outputs on the following falling edge, so exactly one rising edge lies between stimulus and sample. A dedicated latency scenario also reads the outputs just after new inputs are driven, before that edge, and confirms the old value is still held. Overflow boundaries (the most positive and most negative values), distances 0 and 31, and inputs that must be ignored are each sampled at that same one-edge point.

// File: rtl/int_alu_pkg.sv
`timescale 1ns/1ps
package int_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOR  = 5'd7,
    OP_SLT  = 5'd8,
    OP_SLTU = 5'd9,
    OP_SLL  = 5'd10,
    OP_SRL  = 5'd11,
    OP_SRA  = 5'd12,
    OP_SLLV = 5'd13,
    OP_SRLV = 5'd14,
    OP_SRAV = 5'd15,
    OP_ROL  = 5'd16,
    OP_ROR  = 5'd17,
    OP_LUI  = 5'd18
  } alu_op_e;

  // Which functional unit feeds the result register
  typedef enum logic [2:0] {
    SEL_ARITH,
    SEL_LOGIC,
    SEL_CMP,
    SEL_SHIFT,
    SEL_UPPER,
    SEL_ZERO
  } res_sel_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR,
    LG_NOR
  } logic_fn_e;

  typedef struct packed {
    res_sel_e  sel;
    logic      subtract;
    logic      trap_ovf;
    logic      cmp_signed;
    logic_fn_e logic_fn;
    logic      sh_left;
    logic      sh_arith;
    logic      sh_rotate;
    logic      sh_from_b;
  } alu_ctrl_t;
endpackage

// File: rtl/int_alu_addsub.sv
`timescale 1ns/1ps
module int_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             subtract_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             sgn_ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;

  // Subtraction is a + ~b + 1; the carry-in supplies the +1
  assign b_eff = subtract_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, subtract_i};

  // Signed overflow: both addends share a sign the sum does not
  assign sgn_ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/int_alu_logic.sv
`timescale 1ns/1ps
module int_alu_logic
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic_fn_e        fn_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/int_alu_compare.sv
`timescale 1ns/1ps
module int_alu_compare (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic diff_msb_i,
  input  logic signed_i,
  output logic lt_o
);
  // When the sign bits differ the answer is fixed by them; otherwise
  // a-b cannot overflow and its sign bit gives the order.
  always_comb begin
    if (a_msb_i != b_msb_i) begin
      lt_o = signed_i ? a_msb_i : b_msb_i;
    end else begin
      lt_o = diff_msb_i;
    end
  end
endmodule

// File: rtl/int_alu_shifter.sv
`timescale 1ns/1ps
module int_alu_shifter #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [SHW-1:0]   amt_i,
  input  logic             left_i,
  input  logic             arith_i,
  input  logic             rotate_i,
  output logic [WIDTH-1:0] y_o
);
  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH-1:0] bit_rev(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int k = 0; k < WIDTH; k++) r[k] = v[MSB-k];
    return r;
  endfunction

  logic [WIDTH-1:0] stage [SHW+1];
  logic             fill_bit;

  // Left operations run through the same right-going network mirrored
  assign stage[0] = left_i ? bit_rev(data_i) : data_i;
  assign fill_bit = arith_i & ~left_i & data_i[MSB];

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int D = 1 << i;
    logic [D-1:0] fill;
    assign fill = rotate_i ? stage[i][D-1:0] : {D{fill_bit}};
    assign stage[i+1] = amt_i[i] ? {fill, stage[i][MSB:D]} : stage[i];
  end

  assign y_o = left_i ? bit_rev(stage[SHW]) : stage[SHW];
endmodule

// File: rtl/int_alu_core.sv
`timescale 1ns/1ps
module int_alu_core
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH),
  localparam int HALF = WIDTH / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SHW-1:0]   shamt_i,
  output logic [WIDTH-1:0] result_o,
  output logic             ovf_o
);
  alu_op_e   op;
  alu_ctrl_t ctl;

  logic [WIDTH-1:0] arith_y;
  logic             arith_ovf;
  logic [WIDTH-1:0] logic_y;
  logic             lt;
  logic [WIDTH-1:0] shift_y;
  logic [SHW-1:0]   sh_amt;
  logic [WIDTH-1:0] nxt_res;
  logic             nxt_ovf;

  assign op = alu_op_e'(op_i);

  // Decode
  always_comb begin
    ctl = '{sel: SEL_ZERO, subtract: 1'b0, trap_ovf: 1'b0, cmp_signed: 1'b0,
            logic_fn: LG_AND, sh_left: 1'b0, sh_arith: 1'b0,
            sh_rotate: 1'b0, sh_from_b: 1'b0};
    case (op)
      OP_ADD:  begin ctl.sel = SEL_ARITH; ctl.trap_ovf = 1'b1; end
      OP_ADDU: begin ctl.sel = SEL_ARITH; end
      OP_SUB:  begin ctl.sel = SEL_ARITH; ctl.subtract = 1'b1; ctl.trap_ovf = 1'b1; end
      OP_SUBU: begin ctl.sel = SEL_ARITH; ctl.subtract = 1'b1; end
      OP_AND:  begin ctl.sel = SEL_LOGIC; ctl.logic_fn = LG_AND; end
      OP_OR:   begin ctl.sel = SEL_LOGIC; ctl.logic_fn = LG_OR;  end
      OP_XOR:  begin ctl.sel = SEL_LOGIC; ctl.logic_fn = LG_XOR; end
      OP_NOR:  begin ctl.sel = SEL_LOGIC; ctl.logic_fn = LG_NOR; end
      OP_SLT:  begin ctl.sel = SEL_CMP; ctl.subtract = 1'b1; ctl.cmp_signed = 1'b1; end
      OP_SLTU: begin ctl.sel = SEL_CMP; ctl.subtract = 1'b1; end
      OP_SLL:  begin ctl.sel = SEL_SHIFT; ctl.sh_left = 1'b1; end
      OP_SRL:  begin ctl.sel = SEL_SHIFT; end
      OP_SRA:  begin ctl.sel = SEL_SHIFT; ctl.sh_arith = 1'b1; end
      OP_SLLV: begin ctl.sel = SEL_SHIFT; ctl.sh_left = 1'b1; ctl.sh_from_b = 1'b1; end
      OP_SRLV: begin ctl.sel = SEL_SHIFT; ctl.sh_from_b = 1'b1; end
      OP_SRAV: begin ctl.sel = SEL_SHIFT; ctl.sh_arith = 1'b1; ctl.sh_from_b = 1'b1; end
      OP_ROL:  begin ctl.sel = SEL_SHIFT; ctl.sh_left = 1'b1; ctl.sh_rotate = 1'b1;
                     ctl.sh_from_b = 1'b1; end
      OP_ROR:  begin ctl.sel = SEL_SHIFT; ctl.sh_rotate = 1'b1; ctl.sh_from_b = 1'b1; end
      OP_LUI:  begin ctl.sel = SEL_UPPER; end
      default: begin ctl.sel = SEL_ZERO; end
    endcase
  end

  int_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i        (a_i),
    .b_i        (b_i),
    .subtract_i (ctl.subtract),
    .sum_o      (arith_y),
    .sgn_ovf_o  (arith_ovf)
  );

  int_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .fn_i (ctl.logic_fn),
    .y_o  (logic_y)
  );

  int_alu_compare u_cmp (
    .a_msb_i    (a_i[WIDTH-1]),
    .b_msb_i    (b_i[WIDTH-1]),
    .diff_msb_i (arith_y[WIDTH-1]),
    .signed_i   (ctl.cmp_signed),
    .lt_o       (lt)
  );

  assign sh_amt = ctl.sh_from_b ? b_i[SHW-1:0] : shamt_i;

  int_alu_shifter #(.WIDTH(WIDTH)) u_shift (
    .data_i   (a_i),
    .amt_i    (sh_amt),
    .left_i   (ctl.sh_left),
    .arith_i  (ctl.sh_arith),
    .rotate_i (ctl.sh_rotate),
    .y_o      (shift_y)
  );

  // Result select
  always_comb begin
    case (ctl.sel)
      SEL_ARITH: nxt_res = arith_y;
      SEL_LOGIC: nxt_res = logic_y;
      SEL_CMP:   nxt_res = {{(WIDTH-1){1'b0}}, lt};
      SEL_SHIFT: nxt_res = shift_y;
      SEL_UPPER: nxt_res = {b_i[HALF-1:0], {HALF{1'b0}}};
      default:   nxt_res = '0;
    endcase
  end

  assign nxt_ovf = ctl.trap_ovf & arith_ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= nxt_res;
      ovf_o    <= nxt_ovf;
    end
  end
endmodule

// File: rtl/int_alu_checker.sv
`timescale 1ns/1ps
module int_alu_checker
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int HALF = WIDTH / 2
) (
  input logic             clk,
  input logic             rst,
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] result_o,
  input logic             ovf_o
);
  // R1
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (result_o == '0 && !ovf_o));

  // R12: the flag may only follow a signed add or subtract
  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ovf_o) |-> ($past(op_i) == OP_ADD || $past(op_i) == OP_SUB));

  // R5: silent forms never flag and wrap like the signed forms
  assert_silent_add_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_i) == OP_ADDU) |->
      (!ovf_o && result_o == $past(a_i) + $past(b_i)));

  // R3 / R4: a flagged result always has its sign flipped relative to a
  assert_ovf_sign_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ovf_o) |-> (result_o[WIDTH-1] != $past(a_i[WIDTH-1])));

  // R7
  assert_cmp_boolean_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(op_i) == OP_SLT || $past(op_i) == OP_SLTU)) |->
      (result_o[WIDTH-1:1] == '0));

  // R11
  assert_upper_load_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_i) == OP_LUI) |->
      (result_o == {$past(b_i[HALF-1:0]), {HALF{1'b0}}}));
endmodule

bind int_alu_core int_alu_checker #(.WIDTH(WIDTH)) u_int_alu_checker (
  .clk      (clk),
  .rst      (rst),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .ovf_o    (ovf_o)
);

// File: tb/int_alu_core_test.sv
`timescale 1ns/1ps
module int_alu_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] result_o;
  logic        ovf_o;

  int checks = 0;
  int failures = 0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;

  int_alu_core uut (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .shamt_i(shamt_i), .result_o(result_o), .ovf_o(ovf_o)
  );

  // Independent reference built from the requirement text
  task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, output logic [31:0] r, output logic v);
    longint s;
    int n;
    r = 32'h0; v = 1'b0;
    case (op)
      5'd0: begin s = longint'($signed(a)) + longint'($signed(b)); r = a + b;
                  v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      5'd1: r = a + b;
      5'd2: begin s = longint'($signed(a)) - longint'($signed(b)); r = a - b;
                  v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      5'd3: r = a - b;
      5'd4: r = a & b;
      5'd5: r = a | b;
      5'd6: r = a ^ b;
      5'd7: r = ~(a | b);
      5'd8: r = {31'h0, $signed(a) < $signed(b)};
      5'd9: r = {31'h0, a < b};
      5'd10: r = a << sh;
      5'd11: r = a >> sh;
      5'd12: r = $unsigned($signed(a) >>> sh);
      5'd13: r = a << b[4:0];
      5'd14: r = a >> b[4:0];
      5'd15: r = $unsigned($signed(a) >>> b[4:0]);
      5'd16: begin n = int'(b[4:0]); r = (n == 0) ? a : ((a << n) | (a >> (32 - n))); end
      5'd17: begin n = int'(b[4:0]); r = (n == 0) ? a : ((a >> n) | (a << (32 - n))); end
      5'd18: r = {b[15:0], 16'h0};
      default: r = 32'h0;
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input logic aovf, input logic eovf);
    checks++;
    if (act !== exp || aovf !== eovf) begin
      failures++;
      $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b", req, act, aovf, exp, eovf);
    end
  endtask

  // Drive on a falling edge, sample on the next falling edge (one rising edge between)
  task automatic run(input string req, input logic [4:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic [4:0] sh);
    logic [31:0] er;
    logic ev;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; shamt_i = sh;
    model(op, a, b, sh, er, ev);
    @(negedge clk);
    check(req, result_o, er, ovf_o, ev);
  endtask

  task automatic t_reset_r1;
    @(negedge clk);
    op_i = 5'd5; a_i = 32'hFFFF_FFFF; b_i = 32'h1234_5678;
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset", result_o, 32'h0, ovf_o, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_latency_r2;
    run("R2 setup", 5'd4, 32'hF0F0_F0F0, 32'hFF00_FF00, 5'd0);
    @(negedge clk);
    op_i = 5'd6; a_i = 32'hAAAA_0000; b_i = 32'h0000_5555;
    #1;
    check("R2 held before edge", result_o, 32'hF000_F000, ovf_o, 1'b0);
    @(negedge clk);
    check("R2 after one edge", result_o, 32'hAAAA_5555, ovf_o, 1'b0);
  endtask

  task automatic t_add_r3;
    run("R3 plain add", 5'd0, 32'd100, 32'd23, 5'd0);
    run("R3 pos overflow", 5'd0, 32'h7FFF_FFFF, 32'd1, 5'd0);
    run("R3 neg overflow", 5'd0, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0);
    run("R3 mixed signs", 5'd0, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
  endtask

  task automatic t_sub_r4;
    run("R4 plain sub", 5'd2, 32'd5, 32'd9, 5'd0);
    run("R4 min minus one", 5'd2, 32'h8000_0000, 32'd1, 5'd0);
    run("R4 max minus neg", 5'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
    run("R4 same sign", 5'd2, 32'h8000_0000, 32'h8000_0000, 5'd0);
  endtask

  task automatic t_silent_r5;
    run("R5 addu wrap", 5'd1, 32'h7FFF_FFFF, 32'd1, 5'd0);
    run("R5 subu wrap", 5'd3, 32'h8000_0000, 32'd1, 5'd0);
  endtask

  task automatic t_logic_r6;
    for (int f = 4; f <= 7; f++) begin
      run("R6 logic", 5'(f), 32'hC3A5_0FF0, 32'h5A5A_F00F, 5'd0);
    end
  endtask

  task automatic t_cmp_r7;
    run("R7 slt neg<pos", 5'd8, 32'hFFFF_FFFF, 32'd1, 5'd0);
    run("R7 sltu big>small", 5'd9, 32'hFFFF_FFFF, 32'd1, 5'd0);
    run("R7 slt equal", 5'd8, 32'd7, 32'd7, 5'd0);
    run("R7 sltu less", 5'd9, 32'd3, 32'h8000_0000, 5'd0);
  endtask

  task automatic t_shift_const_r8;
    run("R8 sll", 5'd10, 32'h8000_0001, 32'hFFFF_FFFF, 5'd4);
    run("R8 srl", 5'd11, 32'h8000_0010, 32'h0, 5'd31);
    run("R8 sra", 5'd12, 32'h8000_0010, 32'h0, 5'd4);
    run("R8 zero distance", 5'd12, 32'h9234_5678, 32'h0, 5'd0);
  endtask

  task automatic t_shift_var_r9;
    run("R9 sllv high b bits ignored", 5'd13, 32'h0000_00FF, 32'hFFFF_FFE8, 5'd3);
    run("R9 srlv", 5'd14, 32'hF000_0000, 32'h0000_0104, 5'd31);
    run("R9 srav", 5'd15, 32'hF000_0000, 32'h0000_001F, 5'd0);
  endtask

  task automatic t_rotate_r10;
    for (int d = 0; d < 32; d += 7) begin
      run("R10 rol", 5'd16, 32'h8123_4567, 32'(d), 5'd9);
      run("R10 ror", 5'd17, 32'h8123_4567, 32'(d) | 32'hABC0_0000, 5'd9);
    end
    run("R10 ror 31", 5'd17, 32'h0000_0001, 32'd31, 5'd0);
  endtask

  task automatic t_lui_r11;
    run("R11 lui", 5'd18, 32'hFFFF_FFFF, 32'h1234_BEEF, 5'd7);
    run("R11 lui a ignored", 5'd18, 32'h0, 32'h1234_BEEF, 5'd0);
  endtask

  task automatic t_other_r12;
    run("R12 unused opcode", 5'd19, 32'h7FFF_FFFF, 32'd1, 5'd1);
    run("R12 unused 31", 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd1);
    run("R12 sltu no flag", 5'd9, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    t_latency_r2();
    t_add_r3();
    t_sub_r4();
    t_silent_r5();
    t_logic_r6();
    t_cmp_r7();
    t_shift_const_r8();
    t_shift_var_r9();
    t_rotate_r10();
    t_lui_r11();
    t_other_r12();
    t_reset_r1();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!reported) begin
      reported = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end
endmodule